// File: doc/BRIEF.md
# Seeded Two-Polynomial Nonce Generator

This block is a 7-bit linear feedback shift register that supplies a negotiation transmitter with a pseudo-random nonce value and one random bit per page. Each instance is seeded from an 8-bit value, which should be nonzero and different for every instance. It has a one-cycle load/restart pulse and an advance enable. The register steps once per clock while the advance enable is high.

A select input picks one of two degree-7 feedback polynomials. When the select input is 0 the polynomial is x^7 + x^3 + 1. When it is 1 the polynomial is x^7 + x^6 + 1. The select input can change at any time. The new polynomial applies from the next step, and the change does not reload the register. The seed loader folds any seed whose low seven bits are zero to a nonzero value, so the register cannot stick at zero. The host takes `nonce_o` as the nonce field and `rand_bit_o` as the single random codeword bit.

Top module: `nonce_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `nonce_o` at 7'h01 in the following cycle.
- R2: A load at a clock edge with a nonzero seed low part (`seed_i[6:0]` not zero) makes `nonce_o` equal `seed_i[6:0]` in the next cycle.
- R3: A load with `seed_i[6:0]` zero and `seed_i[7]` one puts seed bit 7 in the register's top bit, so `nonce_o` becomes 7'h40.
- R4: A load with the all-zero seed makes `nonce_o` 7'h01.
- R5: With `poly_sel_i` = 0, each step turns state s into {s[5:0], s[6]^s[2]}. From 7'h01 the state first returns to 7'h01 after exactly 127 steps.
- R6: With `poly_sel_i` = 1, each step turns state s into {s[5:0], s[6]^s[5]}. From 7'h01 the state first returns to 7'h01 after exactly 127 steps.
- R7: With `load_i` and `step_en_i` both low, `nonce_o` keeps its value, whatever `seed_i` and `poly_sel_i` do.
- R8: When `load_i` and `step_en_i` are high together, the load wins and the step is discarded.
- R9: `rand_bit_o` equals the state's most significant bit before the step, which is the bit the next step shifts out.
- R10: A change of `poly_sel_i` does not change `nonce_o` by itself. The new polynomial governs the next step.
- R11: `nonce_o` is never zero in any cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_i | input | 8 | Per-instance seed, sampled on load |
| poly_sel_i | input | 1 | Polynomial select: 0 = x^7+x^3+1, 1 = x^7+x^6+1 |
| load_i | input | 1 | Load/restart pulse; reseeds the register |
| step_en_i | input | 1 | Advance enable; one step per clock while high |
| nonce_o | output | 7 | Current register value (nonce field) |
| rand_bit_o | output | 1 | Random codeword bit (state MSB before stepping) |

## Verification
The clocked properties assume that every input is at a known 0 or 1 level at each sampling edge once reset is released. They also assume that the load and step controls may be high together. The properties check only for a nonzero state, the shift relation, hold and feedback, so they make no assumption about how long a seed or a select value stays stable. The bench drives every input from a known value on the falling edge, before the first rising edge after reset. It sweeps all 256 seeds and runs full cycles under both polynomials. The only place it overlaps load and step is the priority check.

// File: rtl/nonce_gen_pkg.sv
package nonce_gen_pkg;

    localparam int STATE_W = 7;
    localparam int SEED_W  = 8;
    localparam int NPOLY   = 2;

    // Lower tap index (besides the MSB) for each selectable polynomial.
    // Index 0: x^7 + x^3 + 1 -> tap bit 2; index 1: x^7 + x^6 + 1 -> tap bit 5.
    localparam int TAP_IDX [NPOLY] = '{2, 5};

    typedef enum logic {
        POLY_X7_X3 = 1'b0,
        POLY_X7_X6 = 1'b1
    } poly_sel_e;

    typedef logic [STATE_W-1:0] lfsr_state_t;

    typedef struct packed {
        logic        load;
        logic        step;
        poly_sel_e   poly;
    } lfsr_ctrl_t;

    localparam lfsr_state_t SAFE_STATE = lfsr_state_t'(1);

    function automatic logic is_zero(input lfsr_state_t s);
        return (s == '0);
    endfunction

endpackage

// File: rtl/nonce_seed_cond.sv
module nonce_seed_cond
    import nonce_gen_pkg::*;
#(
    parameter int SW = SEED_W,
    parameter int RW = STATE_W
) (
    input  logic [SW-1:0] seed_i,
    output logic [RW-1:0] state_o
);
    localparam int UPPER_W = SW - RW;
    localparam int UP_SHIFT = RW - UPPER_W;

    logic [RW-1:0]      low_part;
    logic [UPPER_W-1:0] upper_part;
    logic [RW-1:0]      upper_placed;

    assign low_part     = seed_i[RW-1:0];
    assign upper_part   = seed_i[SW-1:RW];
    assign upper_placed = RW'(upper_part) << UP_SHIFT;

    always_comb begin
        if (low_part != '0) begin
            state_o = low_part;
        end else if (upper_part != '0) begin
            state_o = upper_placed;
        end else begin
            state_o = RW'(1);
        end
    end
endmodule

// File: rtl/nonce_step.sv
module nonce_step
    import nonce_gen_pkg::*;
#(
    parameter int RW = STATE_W
) (
    input  logic [RW-1:0] state_i,
    input  poly_sel_e     poly_i,
    output logic [RW-1:0] next_o
);
    logic [NPOLY-1:0] fb_cand;

    for (genvar p = 0; p < NPOLY; p++) begin : g_poly
        assign fb_cand[p] = state_i[RW-1] ^ state_i[TAP_IDX[p]];
    end

    logic fb;
    assign fb     = fb_cand[int'(poly_i)];
    assign next_o = {state_i[RW-2:0], fb};
endmodule

// File: rtl/nonce_gen.sv
module nonce_gen
    import nonce_gen_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SEED_W-1:0]   seed_i,
    input  logic                poly_sel_i,
    input  logic                load_i,
    input  logic                step_en_i,
    output logic [STATE_W-1:0]  nonce_o,
    output logic                rand_bit_o
);
    lfsr_ctrl_t  ctrl;
    lfsr_state_t state_q;
    lfsr_state_t seeded;
    lfsr_state_t stepped;

    assign ctrl.load = load_i;
    assign ctrl.step = step_en_i;
    assign ctrl.poly = poly_sel_e'(poly_sel_i);

    nonce_seed_cond #(.SW(SEED_W), .RW(STATE_W)) u_seed (
        .seed_i  (seed_i),
        .state_o (seeded)
    );

    nonce_step #(.RW(STATE_W)) u_step (
        .state_i (state_q),
        .poly_i  (ctrl.poly),
        .next_o  (stepped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SAFE_STATE;
        end else if (ctrl.load) begin
            state_q <= seeded;
        end else if (ctrl.step) begin
            state_q <= stepped;
        end
    end

    assign nonce_o    = state_q;
    assign rand_bit_o = state_q[STATE_W-1];

    // R11: register never reaches the lockup value
    assert_never_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !is_zero(nonce_o));

    // R7 / R10: idle cycles leave the state untouched, even if select moves
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_en_i) |=> $stable(nonce_o));

    // R9: a step shifts the old MSB out and the rest up by one
    assert_shift_R9: assert property (@(posedge clk) disable iff (rst)
        (step_en_i && !load_i) |=> nonce_o[STATE_W-1:1] == $past(nonce_o[STATE_W-2:0]));

    // R5 / R6: inserted bit is the old random bit xor the selected tap
    assert_feedback_R5: assert property (@(posedge clk) disable iff (rst)
        (step_en_i && !load_i) |=>
        nonce_o[0] == ($past(rand_bit_o) ^
                       ($past(poly_sel_i) ? $past(nonce_o[5]) : $past(nonce_o[2]))));

    // R2: a nonzero low seed part is loaded verbatim, overriding a step (R8)
    assert_load_low_R2: assert property (@(posedge clk) disable iff (rst)
        (load_i && seed_i[STATE_W-1:0] != '0) |=> nonce_o == $past(seed_i[STATE_W-1:0]));

endmodule

// File: tb/test_nonce_gen.sv
module test_nonce_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] seed_i = 8'h00;
    logic       poly_sel_i = 1'b0;
    logic       load_i = 1'b0;
    logic       step_en_i = 1'b0;
    logic [6:0] nonce_o;
    logic       rand_bit_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    nonce_gen i_nonce_gen (
        .clk(clk), .rst(rst), .seed_i(seed_i), .poly_sel_i(poly_sel_i),
        .load_i(load_i), .step_en_i(step_en_i),
        .nonce_o(nonce_o), .rand_bit_o(rand_bit_o)
    );

    function automatic logic [6:0] model_step(input logic [6:0] s, input logic sel);
        logic fb;
        fb = sel ? (s[6] ^ s[5]) : (s[6] ^ s[2]);
        return {s[5:0], fb};
    endfunction

    function automatic logic [6:0] model_seed(input logic [7:0] sd);
        if (sd[6:0] != 7'd0) return sd[6:0];
        if (sd[7])           return 7'h40;
        return 7'h01;
    endfunction

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] sd);
        seed_i = sd; load_i = 1'b1;
        cycle();
        load_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [6:0] exp_s;
        int first_ret;
        @(negedge clk);
        cycle();
        rst = 1'b0;
        check("R1", nonce_o, 7'h01);

        // R2 R3 R4: exhaustive seed sweep
        for (int sd = 0; sd < 256; sd++) begin
            do_load(8'(sd));
            check(sd == 0 ? "R4" : (sd == 128 ? "R3" : "R2"), nonce_o, model_seed(8'(sd)));
        end

        // R5 R6 R9: full cycles for both polynomials
        for (int sel = 0; sel < 2; sel++) begin
            poly_sel_i = sel[0];
            do_load(8'h01);
            exp_s = 7'h01;
            first_ret = 0;
            step_en_i = 1'b1;
            for (int k = 1; k <= 127; k++) begin
                check("R9", {6'd0, rand_bit_o}, {6'd0, exp_s[6]});
                exp_s = model_step(exp_s, sel[0]);
                cycle();
                check(sel == 0 ? "R5" : "R6", nonce_o, exp_s);
                if (nonce_o == 7'h01 && first_ret == 0) first_ret = k;
            end
            step_en_i = 1'b0;
            check(sel == 0 ? "R5" : "R6", 7'(first_ret), 7'd127);
        end

        // R7: idle with wiggling seed and select
        do_load(8'h5a);
        for (int k = 0; k < 6; k++) begin
            seed_i = 8'(k * 37); poly_sel_i = k[0];
            cycle();
            check("R7", nonce_o, 7'h5a);
        end

        // R8: load wins over step
        do_load(8'h33);
        seed_i = 8'h11; load_i = 1'b1; step_en_i = 1'b1;
        cycle();
        load_i = 1'b0; step_en_i = 1'b0;
        check("R8", nonce_o, 7'h11);

        // R10: select change no reload, applies on next step
        do_load(8'h24);
        poly_sel_i = 1'b0;
        cycle();
        poly_sel_i = 1'b1;
        cycle();
        check("R10", nonce_o, 7'h24);
        step_en_i = 1'b1;
        cycle();
        step_en_i = 1'b0;
        check("R10", nonce_o, model_step(7'h24, 1'b1));
        poly_sel_i = 1'b0;
        step_en_i = 1'b1;
        cycle();
        step_en_i = 1'b0;
        check("R10", nonce_o, model_step(model_step(7'h24, 1'b1), 1'b0));

        // R11: long free run never hits zero, from zero-seed load
        do_load(8'h00);
        poly_sel_i = 1'b1;
        step_en_i = 1'b1;
        for (int k = 0; k < 300; k++) begin
            if (k == 150) poly_sel_i = 1'b0;
            cycle();
            n_vec++;
            if (nonce_o == 7'd0) begin
                n_bad++;
                $display("FAIL R11: actual %h expected nonzero", nonce_o);
            end
        end
        step_en_i = 1'b0;

        // R1 again: reset mid-run
        rst = 1'b1;
        cycle();
        rst = 1'b0;
        check("R1", nonce_o, 7'h01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule